// File: doc/BRIEF.md
# Masked Sub-Line DMA Write Engine

This block lives in an I/O bridge between a DMA write buffer and a coherent system bus. It takes one cache line's worth of DMA write data (64 bytes), the line address, and a mask with one bit per 16-byte chunk. It then puts the enabled chunks into coherent memory.

- **Every chunk enabled:** the engine issues a plain line write.
- **Some chunks enabled:** it first issues a single masked partial write, on the expectation that no CPU cache holds the line modified. Memory skips the chunks whose mask bit is clear. The CPU caches snoop that transaction. A cache that holds the line dirty raises a dirty signal while the write data is still on the bus. In that case the engine replays the access as a locked sequence: it reads the line, merges the new chunks over the fetched ones, and writes the full line back, keeping the bus locked from the read command through the last writeback beat.
- **No chunks enabled:** the request completes with no bus traffic.

The engine takes one request at a time. It holds its request-ready output low until the whole operation, including any fallback, has finished. It marks the finish with a single-cycle done pulse. The data path is 16 bytes wide, so every line transfer is four beats, sent in ascending chunk order.

Top module: `sub_line_writer`

## Requirements
- R1: After reset, reqReady is 1 and busCmdValid, busWrValid, busLock and done are all 0.
- R2: A request with all four mask bits set issues exactly one command with busCmd = 2 (line write), busMask = 4'b1111 and busLock = 0. Four write beats follow. Beat b carries reqData bits [128b+127:128b], in order b = 0..3. busDirty is ignored for this kind of request.
- R3: A request with a mask that is neither zero nor all ones issues a command with busCmd = 1 (partial write) and busMask equal to the request mask. Mask bit b covers bytes 16b..16b+15. Four write beats with the request data follow, in ascending beat order. Every command carries busAddr equal to the request address with its low 6 bits cleared.
- R4: If busDirty stays low during all four beats of a partial write, the request completes with no further bus command.
- R5: If busDirty is high during any beat of a partial write, including the last beat, the engine issues busCmd = 3 (locked read). It accepts four read beats, then issues a line write (busCmd = 2, busMask = 4'b1111). That write's beat b is the request beat b where mask bit b is set, and read beat b elsewhere.
- R6: busLock is 0 for the partial write and its data beats. It is 1 on the locked read command, throughout the read beats, on the writeback command and on all four writeback beats. It is 0 again once done has pulsed.
- R7: A command remains asserted with unchanged busCmd and busMask until the cycle in which busGrant is high.
- R8: reqReady is 0 from the cycle after a request is accepted until the operation completes. A request offered while reqReady is 0 is ignored.
- R9: A request with an all-zero mask produces no bus command and no write beats, and done is high in the cycle after acceptance.
- R10: done is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | DMA request offered |
| reqReady | output | 1 | Engine idle, request accepted when reqValid is high |
| reqAddr | input | 40 | Target line address |
| reqData | input | 512 | Line write data, chunk b in bits [128b+127:128b] |
| reqMask | input | 4 | One enable bit per 16-byte chunk |
| done | output | 1 | One-cycle completion pulse |
| busCmdValid | output | 1 | Command phase active |
| busCmd | output | 2 | 1 partial write, 2 line write, 3 locked read |
| busAddr | output | 40 | Line-aligned command address |
| busMask | output | 4 | Chunk write mask of the command |
| busLock | output | 1 | Bus held for the atomic read-merge-write |
| busGrant | input | 1 | Command accepted this cycle |
| busWrValid | output | 1 | Write data beat valid |
| busWrData | output | 128 | Write data beat |
| busRdValid | input | 1 | Read data beat valid |
| busRdData | input | 128 | Read data beat |
| busDirty | input | 1 | A cache holds the written line modified |

## Verification
Most internal faults surface at the ports within one line transfer, about ten cycles.

- **Wrong beat counter or data register:** shows up in the recorded write beats as a misplaced or stale chunk.
- **Sticky dirty flag not cleared or not set:** shows up as a missing or spurious locked read right after the fourth partial-write beat.
- **Wrong merge select:** corrupts only the writeback beats, chunk by chunk, against the mask.
- **Faulty completion logic:** shows up as a lost, doubled or early done pulse, or as reqReady rising before the last beat.

// File: rtl/slw_pkg.sv
package slw_pkg;
  typedef enum logic [1:0] {
    CMD_NONE   = 2'd0,
    CMD_WRPART = 2'd1,
    CMD_WRLINE = 2'd2,
    CMD_RDLOCK = 2'd3
  } busCmd_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;       // capture a new request line
    logic mergeBeat;  // fold current read beat into the line buffer
  } dpCtl_t;
endpackage

// File: rtl/slw_datapath.sv
module slw_datapath
  import slw_pkg::*;
#(
  parameter int LINE_BYTES = 64,
  parameter int BEAT_BYTES = 16,
  parameter int ADDR_W     = 40,
  localparam int BEATS     = LINE_BYTES / BEAT_BYTES,
  localparam int DATA_W    = BEAT_BYTES * 8,
  localparam int BW        = (BEATS > 1) ? $clog2(BEATS) : 1,
  localparam int OFS_W     = $clog2(LINE_BYTES)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  dpCtl_t                   ctl,
  input  logic [BW-1:0]            beatIdx,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic [LINE_BYTES*8-1:0]  reqData,
  input  logic [BEATS-1:0]         reqMask,
  input  logic [DATA_W-1:0]        busRdData,
  output logic [BEATS-1:0]         maskQ,
  output logic [ADDR_W-1:0]        busAddr,
  output logic [DATA_W-1:0]        busWrData
);
  logic [DATA_W-1:0] lineQ [BEATS];
  logic [ADDR_W-1:0] addrQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ <= '0;
      addrQ <= '0;
    end else if (ctl.load) begin
      maskQ <= reqMask;
      addrQ <= {reqAddr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
    end
  end

  for (genvar b = 0; b < BEATS; b++) begin : gBeat
    always_ff @(posedge clk) begin
      if (!rstN)
        lineQ[b] <= '0;
      else if (ctl.load)
        lineQ[b] <= reqData[b*DATA_W +: DATA_W];
      else if (ctl.mergeBeat && (beatIdx == BW'(b)) && !maskQ[b])
        lineQ[b] <= busRdData;
    end
  end

  assign busAddr   = addrQ;
  assign busWrData = lineQ[beatIdx];

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> $stable(busAddr)); // R3
endmodule

// File: rtl/slw_ctrl.sv
module slw_ctrl
  import slw_pkg::*;
#(
  parameter int BEATS = 4,
  localparam int BW   = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [BEATS-1:0] reqMask,
  input  logic [BEATS-1:0] maskQ,
  input  logic             busGrant,
  input  logic             busRdValid,
  input  logic             busDirty,
  output logic             reqReady,
  output logic             done,
  output logic             busCmdValid,
  output logic [1:0]       busCmd,
  output logic [BEATS-1:0] busMask,
  output logic             busLock,
  output logic             busWrValid,
  output dpCtl_t           ctl,
  output logic [BW-1:0]    beatIdx
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_CMDW, ST_DATAW, ST_CMDR, ST_DATAR, ST_CMDWB, ST_DATAWB, ST_FIN
  } state_e;

  localparam logic [BW-1:0] LAST_BEAT = BW'(BEATS - 1);

  state_e        state, stateNxt;
  logic [BW-1:0] beatQ;
  logic          dirtyQ;
  logic          isFull;
  logic          accept;
  logic          beatStep;
  busCmd_e       cmdSel;

  assign isFull = &maskQ;
  assign accept = reqValid && (state == ST_IDLE);
  assign beatStep = (state == ST_DATAW) || (state == ST_DATAWB) ||
                    ((state == ST_DATAR) && busRdValid);

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE:   if (reqValid) stateNxt = (reqMask == '0) ? ST_FIN : ST_CMDW;
      ST_CMDW:   if (busGrant) stateNxt = ST_DATAW;
      ST_DATAW:  if (beatQ == LAST_BEAT)
                   stateNxt = (!isFull && (dirtyQ || busDirty)) ? ST_CMDR : ST_FIN;
      ST_CMDR:   if (busGrant) stateNxt = ST_DATAR;
      ST_DATAR:  if (busRdValid && beatQ == LAST_BEAT) stateNxt = ST_CMDWB;
      ST_CMDWB:  if (busGrant) stateNxt = ST_DATAWB;
      ST_DATAWB: if (beatQ == LAST_BEAT) stateNxt = ST_FIN;
      ST_FIN:    stateNxt = ST_IDLE;
      default:   stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      beatQ  <= '0;
      dirtyQ <= 1'b0;
    end else begin
      state <= stateNxt;
      if (accept || busGrant)
        beatQ <= '0;
      else if (beatStep)
        beatQ <= beatQ + 1'b1;
      if (accept)
        dirtyQ <= 1'b0;
      else if (state == ST_DATAW && busDirty)
        dirtyQ <= 1'b1;
    end
  end

  always_comb begin
    cmdSel = CMD_NONE;
    if (state == ST_CMDW)       cmdSel = isFull ? CMD_WRLINE : CMD_WRPART;
    else if (state == ST_CMDR)  cmdSel = CMD_RDLOCK;
    else if (state == ST_CMDWB) cmdSel = CMD_WRLINE;
  end

  assign reqReady      = (state == ST_IDLE);
  assign done          = (state == ST_FIN);
  assign busCmdValid   = (state == ST_CMDW) || (state == ST_CMDR) || (state == ST_CMDWB);
  assign busCmd        = cmdSel;
  assign busMask       = (state == ST_CMDW) ? maskQ : '1;
  assign busLock       = (state == ST_CMDR) || (state == ST_DATAR) ||
                         (state == ST_CMDWB) || (state == ST_DATAWB);
  assign busWrValid    = (state == ST_DATAW) || (state == ST_DATAWB);
  assign ctl.load      = accept;
  assign ctl.mergeBeat = (state == ST_DATAR) && busRdValid;
  assign beatIdx       = beatQ;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !busCmdValid && !busWrValid && !busLock); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R10
  AST_LINE_FULL_MASK: assert property (@(posedge clk) disable iff (!rstN)
    busCmdValid && busCmd == CMD_WRLINE |-> &busMask); // R2
  AST_PART_MASK: assert property (@(posedge clk) disable iff (!rstN)
    busCmdValid && busCmd == CMD_WRPART |-> (busMask != '0) && !(&busMask) && !busLock); // R3
  AST_READ_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    busCmdValid && busCmd == CMD_RDLOCK |-> busLock); // R6
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    busCmdValid && !busGrant |=> busCmdValid && $stable(busCmd) && $stable(busMask)); // R7
  AST_LOCK_CONT: assert property (@(posedge clk) disable iff (!rstN)
    busLock && !busWrValid |=> busLock); // R6
endmodule

// File: rtl/sub_line_writer.sv
module sub_line_writer
  import slw_pkg::*;
#(
  parameter int LINE_BYTES = 64,
  parameter int BEAT_BYTES = 16,
  parameter int ADDR_W     = 40,
  localparam int BEATS     = LINE_BYTES / BEAT_BYTES,
  localparam int DATA_W    = BEAT_BYTES * 8,
  localparam int BW        = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  output logic                    reqReady,
  input  logic [ADDR_W-1:0]       reqAddr,
  input  logic [LINE_BYTES*8-1:0] reqData,
  input  logic [BEATS-1:0]        reqMask,
  output logic                    done,
  output logic                    busCmdValid,
  output logic [1:0]              busCmd,
  output logic [ADDR_W-1:0]       busAddr,
  output logic [BEATS-1:0]        busMask,
  output logic                    busLock,
  input  logic                    busGrant,
  output logic                    busWrValid,
  output logic [DATA_W-1:0]       busWrData,
  input  logic                    busRdValid,
  input  logic [DATA_W-1:0]       busRdData,
  input  logic                    busDirty
);
  dpCtl_t           ctl;
  logic [BW-1:0]    beatIdx;
  logic [BEATS-1:0] maskQ;

  slw_ctrl #(.BEATS(BEATS)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqMask(reqMask),
    .maskQ(maskQ), .busGrant(busGrant), .busRdValid(busRdValid),
    .busDirty(busDirty), .reqReady(reqReady), .done(done),
    .busCmdValid(busCmdValid), .busCmd(busCmd), .busMask(busMask),
    .busLock(busLock), .busWrValid(busWrValid), .ctl(ctl), .beatIdx(beatIdx)
  );

  slw_datapath #(.LINE_BYTES(LINE_BYTES), .BEAT_BYTES(BEAT_BYTES), .ADDR_W(ADDR_W)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .beatIdx(beatIdx), .reqAddr(reqAddr),
    .reqData(reqData), .reqMask(reqMask), .busRdData(busRdData),
    .maskQ(maskQ), .busAddr(busAddr), .busWrData(busWrData)
  );
endmodule

// File: tb/tb_sub_line_writer.sv
`timescale 1ns/1ps
module tb_sub_line_writer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [39:0] reqAddr = '0;
  logic [511:0] reqData = '0;
  logic [3:0] reqMask = '0;
  logic done;
  logic busCmdValid;
  logic [1:0] busCmd;
  logic [39:0] busAddr;
  logic [3:0] busMask;
  logic busLock;
  logic busGrant = 1'b0;
  logic busWrValid;
  logic [127:0] busWrData;
  logic busRdValid = 1'b0;
  logic [127:0] busRdData = '0;
  logic busDirty = 1'b0;

  always #10 clk = ~clk;

  sub_line_writer dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqData(reqData), .reqMask(reqMask), .done(done),
    .busCmdValid(busCmdValid), .busCmd(busCmd), .busAddr(busAddr),
    .busMask(busMask), .busLock(busLock), .busGrant(busGrant),
    .busWrValid(busWrValid), .busWrData(busWrData), .busRdValid(busRdValid),
    .busRdData(busRdData), .busDirty(busDirty)
  );

  integer total = 0;
  integer bad = 0;

  // bus model and monitor state
  integer nCmd = 0, nWr = 0, doneCnt = 0, doubleDone = 0;
  logic [1:0]   cmdLog  [0:255];
  logic [3:0]   maskLog [0:255];
  logic         lockLog [0:255];
  logic [39:0]  addrLog [0:255];
  logic [127:0] wrLog   [0:255];
  logic         wrLock  [0:255];
  logic [511:0] rdLine = '0;
  integer dirtyBeat = -1, grantLat = 0, waitCnt = 0, beatInTxn = 0, rdLeft = 0;
  integer rdLockBad = 0, stableBad = 0;
  logic [1:0] curType = 2'd0, lastCmd = 2'd0;
  logic [3:0] lastMask = 4'd0;
  logic lastPend = 1'b0, prevDone = 1'b0;

  always @(negedge clk) begin
    // read beats for a granted locked read
    busRdValid = 1'b0;
    if (rdLeft > 0) begin
      busRdValid = 1'b1;
      busRdData  = rdLine[(4-rdLeft)*128 +: 128];
      if (!busLock) rdLockBad = rdLockBad + 1;
      rdLeft = rdLeft - 1;
    end
    // hold check on pending commands
    if (lastPend) begin
      if (!busCmdValid || busCmd != lastCmd || busMask != lastMask)
        stableBad = stableBad + 1;
    end
    // grant
    busGrant = 1'b0;
    if (busCmdValid) begin
      if (waitCnt >= grantLat) begin
        busGrant = 1'b1;
        waitCnt = 0;
        cmdLog[nCmd] = busCmd; maskLog[nCmd] = busMask;
        lockLog[nCmd] = busLock; addrLog[nCmd] = busAddr;
        nCmd = nCmd + 1;
        curType = busCmd;
        beatInTxn = 0;
        if (busCmd == 2'd3) rdLeft = 4;
      end else
        waitCnt = waitCnt + 1;
    end else
      waitCnt = 0;
    lastPend = busCmdValid && !busGrant;
    lastCmd = busCmd; lastMask = busMask;
    // write beats and dirty response
    busDirty = 1'b0;
    if (busWrValid) begin
      if (dirtyBeat == 4 || (curType == 2'd1 && beatInTxn == dirtyBeat))
        busDirty = 1'b1;
      wrLog[nWr] = busWrData; wrLock[nWr] = busLock;
      nWr = nWr + 1;
      beatInTxn = beatInTxn + 1;
    end
    if (done) doneCnt = doneCnt + 1;
    if (done && prevDone) doubleDone = doubleDone + 1;
    prevDone = done;
  end

  task automatic chk(input string tag, input logic [511:0] act, input logic [511:0] exp,
                     input string what);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [511:0] mkLine(input int seed);
    logic [511:0] v;
    for (int i = 0; i < 64; i++) v[i*8 +: 8] = 8'(seed * 13 + i * 7 + 1);
    return v;
  endfunction

  // one scenario: dBeat -1 none, 0..3 on that partial beat, 4 on every beat
  task automatic runCase(input string tag, input logic [3:0] m, input int seed,
                         input int dBeat, input int lat, input bit poke);
    logic [511:0] d, rl, mergeExp;
    logic [39:0] a;
    int c0, w0, dc0, cyc;
    bit dirtyHit, full, zero;
    d  = mkLine(seed);
    rl = mkLine(seed + 100);
    a  = 40'h12_3456_7800 + 40'(seed * 64) + 40'h2b;
    full = (m == 4'hF);
    zero = (m == 4'h0);
    dirtyHit = !full && !zero && dBeat >= 0;
    for (int b = 0; b < 4; b++)
      mergeExp[b*128 +: 128] = m[b] ? d[b*128 +: 128] : rl[b*128 +: 128];
    rdLine = rl; dirtyBeat = dBeat; grantLat = lat;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    c0 = nCmd; w0 = nWr; dc0 = doneCnt;
    reqValid = 1'b1; reqData = d; reqMask = m; reqAddr = a;
    @(negedge clk);
    if (zero) chk({tag, " R9"}, 512'(done), 512'd1, "done after zero-mask accept");
    if (poke) begin
      chk({tag, " R8"}, 512'(reqReady), 512'd0, "ready while busy");
      reqData = ~d; reqMask = ~m; reqAddr = ~a;
      repeat (3) @(negedge clk);
      chk({tag, " R8"}, 512'(reqReady), 512'd0, "ready while still busy");
    end
    reqValid = 1'b0;
    cyc = 0;
    while (!done && cyc < 300) begin @(negedge clk); cyc++; end
    @(negedge clk);
    chk({tag, " R10"}, 512'(done), 512'd0, "done one cycle");
    chk({tag, " R6"}, 512'(busLock), 512'd0, "lock after done");
    @(negedge clk);
    chk({tag, " R10"}, 512'(doneCnt - dc0), 512'd1, "done pulses");
    if (zero) begin
      chk({tag, " R9"}, 512'(nCmd - c0), 512'd0, "commands");
      chk({tag, " R9"}, 512'(nWr - w0), 512'd0, "write beats");
    end else begin
      chk({tag, " R4"}, 512'(nCmd - c0), dirtyHit ? 512'd3 : 512'd1, "command count");
      chk({tag, full ? " R2" : " R3"}, 512'(cmdLog[c0]), full ? 512'd2 : 512'd1, "first cmd");
      chk({tag, " R3"}, 512'(maskLog[c0]), 512'(m), "first mask");
      chk({tag, " R3"}, 512'(addrLog[c0]), 512'({a[39:6], 6'd0}), "address");
      chk({tag, " R6"}, 512'(lockLog[c0]), 512'd0, "first cmd lock");
      chk({tag, " R4"}, 512'(nWr - w0), dirtyHit ? 512'd8 : 512'd4, "write beat count");
      for (int b = 0; b < 4; b++) begin
        chk({tag, " R3"}, 512'(wrLog[w0 + b]), 512'(d[b*128 +: 128]), $sformatf("beat %0d", b));
        chk({tag, " R6"}, 512'(wrLock[w0 + b]), 512'd0, "first write lock");
      end
      if (dirtyHit) begin
        chk({tag, " R5"}, 512'(cmdLog[c0 + 1]), 512'd3, "locked read cmd");
        chk({tag, " R6"}, 512'(lockLog[c0 + 1]), 512'd1, "read cmd lock");
        chk({tag, " R5"}, 512'(cmdLog[c0 + 2]), 512'd2, "writeback cmd");
        chk({tag, " R5"}, 512'(maskLog[c0 + 2]), 512'hF, "writeback mask");
        chk({tag, " R6"}, 512'(lockLog[c0 + 2]), 512'd1, "writeback cmd lock");
        for (int b = 0; b < 4; b++) begin
          chk({tag, " R5"}, 512'(wrLog[w0 + 4 + b]), 512'(mergeExp[b*128 +: 128]),
              $sformatf("merged beat %0d", b));
          chk({tag, " R6"}, 512'(wrLock[w0 + 4 + b]), 512'd1, "writeback lock");
        end
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total = total + 1; bad = bad + 1;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("reset R1", 512'(reqReady), 512'd1, "reqReady");
    chk("reset R1", 512'({busCmdValid, busWrValid, busLock, done}), 512'd0, "bus/done idle");
    runCase("full_dirty", 4'hF, 1, 4, 0, 0);        // R2 dirty ignored
    runCase("part_clean", 4'h5, 2, -1, 2, 0);       // R3 R4
    runCase("part_dirty0", 4'h3, 3, 0, 1, 0);       // R5 R6
    runCase("part_dirty3", 4'hE, 4, 3, 3, 0);       // R5 last beat
    runCase("part_busy", 4'h8, 5, -1, 5, 1);        // R8 R7
    runCase("zero_mask", 4'h0, 6, 4, 0, 0);         // R9
    runCase("part_dirty2", 4'h1, 7, 2, 0, 0);       // R5
    runCase("full_clean", 4'hF, 8, -1, 2, 0);       // R2
    chk("hold R7", 512'(stableBad), 512'd0, "command changed before grant");
    chk("lock R6", 512'(rdLockBad), 512'd0, "read beats without lock");
    chk("pulse R10", 512'(doubleDone), 512'd0, "done longer than one cycle");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule